// File: doc/BRIEF.md
# Timestamping Quadrature Decoder with Revolution Check

This block turns the three raw signals of one incremental rotary encoder (two quadrature phases and a once-per-turn marker) into a signed position count. It decodes direction from the order in which the two phases change, so it does not simply count raw edges. Two or more instances can share one free-running 24-bit timer. Each instance tags every step that carries the shaft further forward than it has been before with the timer value of that step. A downstream stage can then line up the arrival times of matching positions on different encoders.

The once-per-turn marker checks the count. An encoder with 2000 lines gives 8000 quadrature counts per turn, so the net count between two consecutive markers must be a whole multiple of that figure. A count that disagrees raises a sticky flag. A sample in which both phases flip at once cannot be decoded. The block drops that step and raises a second sticky flag. Software clears either flag with a write strobe and a data word, one bit per flag.

The design targets a 100 MHz clock. At 10000 rpm there are about 75 clocks between counts, so the block works on plain synchronised sampling with no filtering.

Top module: `enc_stamp_decoder`

## Requirements
- R1: After reset, position is 0, dirUp is 1, and stampValid, errIllegal and errIndex are 0.
- R2: The pair (encA, encB) counts up along the cycle 00, 10, 11, 01, 00 and down along the reverse cycle. Each change of exactly one phase is one count.
- R3: If both phases differ from the previous sample, the position does not change and errIllegal is set. errIllegal stays set until it is cleared.
- R4: dirUp is 1 after an upward count and 0 after a downward count. It holds its value through samples with no count.
- R5: When an upward count takes the position above the highest value reached since reset, stampValid pulses for one clock. In that clock, stampTime holds the timer input sampled at the same edge that updates the position, and stampPos holds the new position.
- R6: Counts that only revisit positions at or below that maximum produce no stamp. This covers jitter across an edge and moves backward followed by moves forward.
- R7: The first rising edge of encIdx after reset never raises errIndex. It only sets the reference for later checks.
- R8: At every later rising edge of encIdx, errIndex is set if the net count since the previous rising edge is not a multiple of CPR (default 8000). The count includes any step in the same sample. errIndex is sticky, and every rising edge restarts the reference.
- R9: When clrWe is 1, clrData bit 0 clears errIllegal and clrData bit 1 clears errIndex. A new error in the same clock takes priority over the clear.
- R10: Each of encA, encB and encIdx passes through a two-flop synchroniser. The outputs respond on the third rising clock edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encA | input | 1 | Quadrature phase A (asynchronous) |
| encB | input | 1 | Quadrature phase B (asynchronous) |
| encIdx | input | 1 | Once-per-turn marker (asynchronous) |
| timerVal | input | 24 | Shared free-running timer value |
| clrWe | input | 1 | Flag-clear write strobe |
| clrData | input | 2 | Write-one-to-clear bits: bit 0 clears errIllegal, bit 1 clears errIndex |
| position | output | 32 | Signed position count |
| dirUp | output | 1 | Direction of the last count (1 = up) |
| stampValid | output | 1 | One-clock strobe marking a new forward maximum |
| stampTime | output | 24 | Timer value captured with the stamp |
| stampPos | output | 32 | Position captured with the stamp |
| errIllegal | output | 1 | Sticky flag for an undecodable double-phase change |
| errIndex | output | 1 | Sticky flag for a count/marker mismatch |

## Verification
The assertions check on every clock that the position moves by at most one count and that the decoder never asserts more than one of up, down and illegal at once. They also check that every stamp coincides with a one-count rise of the position and carries that position, and that both error flags stay set until a matching clear arrives. Some behaviour needs directed scenarios compared against the bench's behavioural model: the phase order that defines forward, the suppression of stamps while the shaft jitters below its maximum, a first marker that is excused while a later one is checked after exactly 8000 and after 8001 counts, the priority of a new error over a clear in the same clock, and the three-edge latency.

// File: rtl/qd_pkg.sv
package qd_pkg;
  // Per-sample decode result handed from control to datapath
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic illegal;
    logic idxRise;
  } qdStrobe_t;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/qd_ctrl.sv
module qd_ctrl
  import qd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncA,
  input  logic      syncB,
  input  logic      syncIdx,
  output qdStrobe_t strobe
);
  logic prevA, prevB, prevIdx;
  logic chA, chB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA   <= 1'b0;
      prevB   <= 1'b0;
      prevIdx <= 1'b0;
    end else begin
      prevA   <= syncA;
      prevB   <= syncB;
      prevIdx <= syncIdx;
    end
  end

  always_comb begin
    chA            = syncA ^ prevA;
    chB            = syncB ^ prevB;
    strobe.illegal = chA & chB;
    // A single-phase change is forward when new A differs from old B
    strobe.stepUp  = (chA ^ chB) & (syncA ^ prevB);
    strobe.stepDn  = (chA ^ chB) & ~(syncA ^ prevB);
    strobe.idxRise = syncIdx & ~prevIdx;
  end
endmodule

// File: rtl/qd_datapath.sv
module qd_datapath
  import qd_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int TS_W  = 24,
  parameter int CPR   = 8000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  qdStrobe_t               strobe,
  input  logic [TS_W-1:0]         timerVal,
  input  logic                    clrWe,
  input  logic [1:0]              clrData,
  output logic signed [POS_W-1:0] position,
  output logic                    dirUp,
  output logic                    stampValid,
  output logic [TS_W-1:0]         stampTime,
  output logic signed [POS_W-1:0] stampPos,
  output logic                    errIllegal,
  output logic                    errIndex
);
  localparam int PH_W = $clog2(CPR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CPR - 1);

  logic signed [POS_W-1:0] maxPos, posNext;
  logic [PH_W-1:0]         phase, phaseNext;
  logic                    idxSeen;
  logic                    idxBad;

  always_comb begin
    posNext   = position;
    phaseNext = phase;
    if (strobe.stepUp) begin
      posNext   = position + POS_W'(1);
      phaseNext = (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    end else if (strobe.stepDn) begin
      posNext   = position - POS_W'(1);
      phaseNext = (phase == '0) ? PH_LAST : phase - PH_W'(1);
    end
    idxBad = strobe.idxRise && idxSeen && (phaseNext != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position   <= '0;
      maxPos     <= '0;
      phase      <= '0;
      idxSeen    <= 1'b0;
      dirUp      <= 1'b1;
      stampValid <= 1'b0;
      stampTime  <= '0;
      stampPos   <= '0;
      errIllegal <= 1'b0;
      errIndex   <= 1'b0;
    end else begin
      position   <= posNext;
      phase      <= strobe.idxRise ? '0 : phaseNext;
      if (strobe.idxRise) idxSeen <= 1'b1;
      if (strobe.stepUp)      dirUp <= 1'b1;
      else if (strobe.stepDn) dirUp <= 1'b0;
      stampValid <= 1'b0;
      if (strobe.stepUp && (posNext > maxPos)) begin
        maxPos     <= posNext;
        stampValid <= 1'b1;
        stampTime  <= timerVal;
        stampPos   <= posNext;
      end
      if (strobe.illegal)               errIllegal <= 1'b1;
      else if (clrWe && clrData[0])     errIllegal <= 1'b0;
      if (idxBad)                       errIndex   <= 1'b1;
      else if (clrWe && clrData[1])     errIndex   <= 1'b0;
    end
  end

  // R2: position moves by at most one count per clock
  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (position == $past(position)) || (position == $past(position) + POS_W'(1)) ||
    (position == $past(position) - POS_W'(1)));

  // R3: decoder never reports two outcomes for one sample
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepUp, strobe.stepDn, strobe.illegal}));

  // R3: illegal flag is sticky until cleared
  p_illegal_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    errIllegal && !(clrWe && clrData[0]) |=> errIllegal);

  // R8: index flag is sticky until cleared
  p_idx_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errIndex && !(clrWe && clrData[1]) |=> errIndex);

  // R5: a stamp accompanies a one-count rise and carries that position
  p_stamp_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |-> (stampPos == position) && (position == $past(position) + POS_W'(1)));

  // R6: a stamp only ever marks a position above the earlier maximum
  p_stamp_fresh_r6: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |-> $past(position) == $past(maxPos));
endmodule

// File: rtl/enc_stamp_decoder.sv
module enc_stamp_decoder
  import qd_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int TS_W        = 24,
  parameter int CPR         = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    encA,
  input  logic                    encB,
  input  logic                    encIdx,
  input  logic [TS_W-1:0]         timerVal,
  input  logic                    clrWe,
  input  logic [1:0]              clrData,
  output logic signed [POS_W-1:0] position,
  output logic                    dirUp,
  output logic                    stampValid,
  output logic [TS_W-1:0]         stampTime,
  output logic signed [POS_W-1:0] stampPos,
  output logic                    errIllegal,
  output logic                    errIndex
);
  logic [2:0] syncBus;
  qdStrobe_t  strobe;

  qd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({encIdx, encB, encA}),
    .dOut (syncBus)
  );

  qd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncA   (syncBus[0]),
    .syncB   (syncBus[1]),
    .syncIdx (syncBus[2]),
    .strobe  (strobe)
  );

  qd_datapath #(.POS_W(POS_W), .TS_W(TS_W), .CPR(CPR)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .timerVal   (timerVal),
    .clrWe      (clrWe),
    .clrData    (clrData),
    .position   (position),
    .dirUp      (dirUp),
    .stampValid (stampValid),
    .stampTime  (stampTime),
    .stampPos   (stampPos),
    .errIllegal (errIllegal),
    .errIndex   (errIndex)
  );
endmodule

// File: tb/tb_enc_stamp_decoder.sv
module tb_enc_stamp_decoder;
  localparam int CPR = 8000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               encA = 1'b0, encB = 1'b0, encIdx = 1'b0;
  logic [23:0]        timerVal = '0;
  logic               clrWe = 1'b0;
  logic [1:0]         clrData = '0;
  logic signed [31:0] position, stampPos;
  logic               dirUp, stampValid, errIllegal, errIndex;
  logic [23:0]        stampTime;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  enc_stamp_decoder dut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .timerVal(timerVal), .clrWe(clrWe), .clrData(clrData),
    .position(position), .dirUp(dirUp), .stampValid(stampValid),
    .stampTime(stampTime), .stampPos(stampPos),
    .errIllegal(errIllegal), .errIndex(errIndex)
  );

  always @(negedge clk) timerVal <= timerVal + 24'd1;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] h1 = '0, h2 = '0, h3 = '0;  // {idx,b,a} one, two, three edges ago
  longint mPos = 0, mMax = 0, mRef = 0;
  bit     mSeen = 0, mDir = 1, mIll = 0, mIdx = 0, mStV = 0;
  longint mStT = 0, mStP = 0;

  function automatic int phaseOf(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h1 = '0; h2 = '0; h3 = '0;
      mPos = 0; mMax = 0; mRef = 0; mSeen = 0; mDir = 1;
      mIll = 0; mIdx = 0; mStV = 0; mStT = 0; mStP = 0;
    end else begin
      int d;
      bit up, dn, ill, rise, bad;
      d    = (phaseOf(h2[0], h2[1]) - phaseOf(h3[0], h3[1]) + 4) % 4;
      up   = (d == 1);
      dn   = (d == 3);
      ill  = (d == 2);
      rise = h2[2] && !h3[2];
      if (up) begin mPos++; mDir = 1; end
      if (dn) begin mPos--; mDir = 0; end
      mStV = 0;
      if (up && mPos > mMax) begin
        mMax = mPos; mStV = 1; mStT = timerVal; mStP = mPos;
      end
      if (ill) mIll = 1;
      else if (clrWe && clrData[0]) mIll = 0;
      bad = rise && mSeen && (((mPos - mRef) % CPR) != 0);
      if (bad) mIdx = 1;
      else if (clrWe && clrData[1]) mIdx = 0;
      if (rise) begin mRef = mPos; mSeen = 1; end
      h3 = h2; h2 = h1; h1 = {encIdx, encB, encA};
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 position", position, mPos);
      chk("R4 dirUp", dirUp, mDir);
      chk("R5 stampValid", stampValid, mStV);
      if (mStV) begin
        chk("R5 stampTime", stampTime, mStT);
        chk("R5 stampPos", stampPos, mStP);
      end
      chk("R3 errIllegal", errIllegal, mIll);
      chk("R8 errIndex", errIndex, mIdx);
    end
  end

  // ---------------- stimulus ----------------
  int curPh = 0;

  task automatic driveAB();
    case (curPh)
      0: {encA, encB} = 2'b00;
      1: {encA, encB} = 2'b10;
      2: {encA, encB} = 2'b11;
      default: {encA, encB} = 2'b01;
    endcase
  endtask

  task automatic steps(input int n, input bit fwd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      curPh = fwd ? (curPh + 1) % 4 : (curPh + 3) % 4;
      driveAB();
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseIdx();
    @(negedge clk) encIdx = 1'b1;
    idle(2);
    encIdx = 1'b0;
    idle(5);
  endtask

  task automatic clearFlags(input logic [1:0] bits);
    @(negedge clk); clrWe = 1'b1; clrData = bits;
    @(negedge clk); clrWe = 1'b0; clrData = '0;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R1: reset state
    chk("R1 position", position, 0);
    chk("R1 dirUp", dirUp, 1);
    chk("R1 stampValid", stampValid, 0);
    chk("R1 errIllegal", errIllegal, 0);
    chk("R1 errIndex", errIndex, 0);

    // R10: latency of three rising edges
    steps(1, 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 position after two edges", position, 0);
    @(negedge clk);
    chk("R10 position after three edges", position, 1);
    chk("R5 first stamp", stampValid, 1);
    idle(3);

    // R2/R5: forward run, one count per clock and spaced
    steps(10, 1);
    idle(4);
    for (int i = 0; i < 4; i++) begin steps(1, 1); idle(3); end
    chk("R2 forward total", position, 15);

    // R4/R6: back off then return, then jitter across an edge
    steps(3, 0);
    idle(4);
    chk("R4 dirUp after reverse", dirUp, 0);
    steps(3, 1);
    for (int i = 0; i < 6; i++) begin steps(1, 0); idle(1); steps(1, 1); idle(1); end
    idle(4);
    chk("R6 position back at max", position, 15);
    steps(2, 1);
    idle(4);

    // R3: both phases flip in one sample
    @(negedge clk); curPh = (curPh + 2) % 4; driveAB();
    idle(5);
    chk("R3 flag set", errIllegal, 1);
    chk("R3 count held", position, 17);
    clearFlags(2'b10);
    chk("R9 wrong bit leaves illegal", errIllegal, 1);
    clearFlags(2'b01);
    chk("R9 illegal cleared", errIllegal, 0);

    // R9: clear held while a new illegal change arrives: set wins that clock
    @(negedge clk); clrWe = 1'b1; clrData = 2'b01;
    curPh = (curPh + 2) % 4; driveAB();
    idle(6);
    clrWe = 1'b0; clrData = '0;
    steps(4, 1);
    idle(4);

    // R7: first marker is excused
    pulseIdx();
    chk("R7 first index", errIndex, 0);
    // R8: exactly one turn forward
    steps(CPR, 1);
    idle(3);
    pulseIdx();
    chk("R8 exact turn", errIndex, 0);
    // R8: one turn in reverse
    steps(CPR, 0);
    idle(3);
    pulseIdx();
    chk("R8 reverse turn", errIndex, 0);
    // R8: one count too many
    steps(CPR + 1, 1);
    idle(3);
    pulseIdx();
    chk("R8 mismatch flagged", errIndex, 1);
    clearFlags(2'b01);
    chk("R9 wrong bit leaves index", errIndex, 1);
    clearFlags(2'b10);
    chk("R9 index cleared", errIndex, 0);
    // R8: reference restarted at the bad marker, next exact turn is clean
    steps(CPR, 1);
    idle(3);
    pulseIdx();
    chk("R8 reference restarted", errIndex, 0);

    idle(5);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule